// File: doc/BRIEF.md
# Packed Signed-Saturating Narrowing Unit

This block is one stage of a 64-bit SIMD datapath. It takes two packed 64-bit operands and narrows them into one 64-bit result. Each signed lane is converted to half its width. A lane that does not fit in the narrower signed range is clamped to the nearest limit. The narrowed lanes of the first operand fill the low half of the result, and those of the second operand fill the high half.

An 8-bit opcode selects one of two lane widths. The value 0x63 narrows 16-bit lanes to 8-bit lanes. The value 0x6B narrows 32-bit lanes to 16-bit lanes. Any other opcode is reported as illegal.

The result is registered and appears one cycle after a valid strobe. It comes with three flags: a valid flag, a saturation flag that reports whether any lane was clamped, and an illegal-opcode flag.

Top module: `sat_narrow`

## Requirements
- R1: With opcode 0x63, result byte i (i = 0..3, bits 8i+7:8i) holds the narrowed 16-bit lane i of the first operand, where lane i is bits 16i+15:16i.
- R2: With opcode 0x63, result byte 4+i holds the narrowed 16-bit lane i of the second operand.
- R3: In 16-to-8 mode, a lane above 127 yields 0x7F and a lane below -128 yields 0x80.
- R4: With opcode 0x6B, result words 0 and 1 (bits 15:0 and 31:16) come from the 32-bit lanes 0 and 1 of the first operand, and words 2 and 3 come from lanes 0 and 1 of the second operand.
- R5: In 32-to-16 mode, a lane above 32767 yields 0x7FFF and a lane below -32768 yields 0x8000.
- R6: A lane whose value fits the target signed range passes through as its low bits, unchanged.
- R7: Any opcode other than 0x63 or 0x6B sets the illegal flag, gives a zero result and clears the saturation flag. A legal opcode clears the illegal flag.
- R8: The result valid flag equals the input valid strobe one cycle earlier. The result and the other flags reflect that accepted input.
- R9: The saturation flag is 1 exactly when at least one of the lanes of the accepted input was clamped.
- R10: Synchronous active-high reset clears the valid flag, the result, the saturation flag and the illegal flag.
- R11: While the valid strobe is low, the result and the flags keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; the operands and opcode are accepted when it is high |
| op_code | input | 8 | Mode select: 0x63 for 16-to-8, 0x6B for 32-to-16 |
| opnd_a | input | 64 | First operand; fills the low half of the result |
| opnd_b | input | 64 | Second operand; fills the high half of the result |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 64 | Narrowed result |
| out_sat | output | 1 | At least one lane was clamped |
| out_illegal | output | 1 | The opcode was not recognised |

## Verification
The assertions assume that the opcode and both operands are known (not X) in every cycle where in_valid is high. They also assume that reset is held long enough to clear the registers before the first strobe. The stimulus drives every input on the falling edge, holds reset for several cycles, and uses only defined values. These include targeted lane boundaries at ±127/128 and ±32767/32768, and random operands. Gaps with in_valid low are mixed in, so that the hold behaviour is exercised between results.

// File: rtl/sat_narrow.sv
module sat_narrow #(
  parameter int         W     = 64,
  parameter logic [7:0] OP_WB = 8'h63,
  parameter logic [7:0] OP_DW = 8'h6B
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [7:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_sat,
  output logic         out_illegal
);
  localparam int CW  = 2 * W;
  localparam int NWB = CW / 16;
  localparam int NDW = CW / 32;

  logic [CW-1:0]  cat;
  logic [W-1:0]   res_wb, res_dw, nxt_data;
  logic [NWB-1:0] clip_wb;
  logic [NDW-1:0] clip_dw;
  logic           is_wb, is_dw, nxt_sat;

  assign cat   = {opnd_b, opnd_a};
  assign is_wb = (op_code == OP_WB);
  assign is_dw = (op_code == OP_DW);

  for (genvar g = 0; g < NWB; g++) begin : g_wb
    logic [15:0] ln;
    logic        hi, lo;
    assign ln = cat[16*g +: 16];
    assign hi = !ln[15] && (|ln[14:7]);
    assign lo =  ln[15] && !(&ln[14:7]);
    assign res_wb[8*g +: 8] = hi ? 8'h7F : (lo ? 8'h80 : ln[7:0]);
    assign clip_wb[g] = hi | lo;
  end

  for (genvar g = 0; g < NDW; g++) begin : g_dw
    logic [31:0] ln;
    logic        hi, lo;
    assign ln = cat[32*g +: 32];
    assign hi = !ln[31] && (|ln[30:15]);
    assign lo =  ln[31] && !(&ln[30:15]);
    assign res_dw[16*g +: 16] = hi ? 16'h7FFF : (lo ? 16'h8000 : ln[15:0]);
    assign clip_dw[g] = hi | lo;
  end

  assign nxt_data = is_wb ? res_wb : (is_dw ? res_dw : '0);
  assign nxt_sat  = is_wb ? (|clip_wb) : (is_dw ? (|clip_dw) : 1'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_sat     <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= nxt_data;
        out_sat     <= nxt_sat;
        out_illegal <= !(is_wb || is_dw);
      end
    end
  end
endmodule

// File: rtl/sat_narrow_chk.sv
module sat_narrow_chk #(
  parameter int         W     = 64,
  parameter logic [7:0] OP_WB = 8'h63,
  parameter logic [7:0] OP_DW = 8'h6B
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [7:0]   op_code,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_sat,
  input logic         out_illegal
);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid));

  a_r7_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_data == '0 && !out_sat));

  a_r7_decode: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |->
      out_illegal == !($past(op_code) == OP_WB || $past(op_code) == OP_DW));

  a_r3_word_clip_hi: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(op_code) == OP_WB &&
     $signed($past(opnd_a[15:0])) > 16'sd127) |-> (out_data[7:0] == 8'h7F && out_sat));

  a_r5_dword_clip_lo: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(op_code) == OP_DW &&
     $signed($past(opnd_a[31:0])) < -32'sd32768) |-> (out_data[15:0] == 16'h8000 && out_sat));

  a_r2_high_pass: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(op_code) == OP_WB &&
     $past(opnd_b[15:7]) == 9'h000) |-> out_data[39:32] == $past(opnd_b[7:0]));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |->
      ($stable(out_data) && $stable(out_sat) && $stable(out_illegal)));
endmodule

bind sat_narrow sat_narrow_chk #(.W(W), .OP_WB(OP_WB), .OP_DW(OP_DW)) chk_i (.*);

// File: tb/sat_narrow_tb.sv
module sat_narrow_tb_top;
  typedef struct {
    logic [63:0] data;
    logic        sat;
    logic        ill;
    string       tag;
  } item_t;

  logic        clk = 0, rst = 1, in_valid = 0;
  logic [7:0]  op_code = 0;
  logic [63:0] opnd_a = 0, opnd_b = 0;
  logic        out_valid, out_sat, out_illegal;
  logic [63:0] out_data;

  item_t       sb[$];
  int          n_chk = 0, n_fail = 0;
  bit          seen = 0;
  logic [63:0] last_data;
  logic        last_sat, last_ill;

  sat_narrow dut_i (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b,
                                        output logic s, output logic ill);
    logic [127:0] c;
    logic [63:0]  r;
    int           v;
    c = {b, a}; r = 0; s = 0; ill = 0;
    if (op == 8'h63) begin
      for (int i = 0; i < 8; i++) begin
        v = int'($signed(c[16*i +: 16]));
        if (v > 127)       begin r[8*i +: 8] = 8'h7F; s = 1; end
        else if (v < -128) begin r[8*i +: 8] = 8'h80; s = 1; end
        else r[8*i +: 8] = v[7:0];
      end
    end else if (op == 8'h6B) begin
      for (int i = 0; i < 4; i++) begin
        v = int'($signed(c[32*i +: 32]));
        if (v > 32767)       begin r[16*i +: 16] = 16'h7FFF; s = 1; end
        else if (v < -32768) begin r[16*i +: 16] = 16'h8000; s = 1; end
        else r[16*i +: 16] = v[15:0];
      end
    end else ill = 1;
    return r;
  endfunction

  task automatic send(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1; op_code = op; opnd_a = a; opnd_b = b;
    it.data = model(op, a, b, it.sat, it.ill);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; op_code = $urandom; opnd_a = {$urandom, $urandom}; opnd_b = {$urandom, $urandom};
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst) begin
        if (out_valid) begin
          if (sb.size() == 0) check(0, "R8 unexpected valid", 64'd1, 64'd0);
          else begin
            item_t e;
            e = sb.pop_front();
            check(out_data == e.data, e.tag, out_data, e.data);
            check(out_sat == e.sat, "R9 sat flag", {63'd0, out_sat}, {63'd0, e.sat});
            check(out_illegal == e.ill, "R7 illegal flag", {63'd0, out_illegal}, {63'd0, e.ill});
            last_data = e.data; last_sat = e.sat; last_ill = e.ill; seen = 1;
          end
        end else if (seen) begin
          check(out_data == last_data && out_sat == last_sat && out_illegal == last_ill,
                "R11 hold while idle", out_data, last_data);
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic reset_check();
    @(negedge clk); #1;
    // R10: all outputs cleared
    check(out_valid == 0 && out_data == 0 && out_sat == 0 && out_illegal == 0,
          "R10 reset state", out_data, 64'd0);
  endtask

  initial begin
    idle(1);
    rst = 1; in_valid = 1; op_code = 8'h63; opnd_a = '1;
    repeat (4) @(negedge clk);
    reset_check();
    @(negedge clk); rst = 0; in_valid = 0;
    idle(2);
    // R1 R2 R6: in-range pass-through, lane order
    send(8'h63, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005, "R1 R2 R6 word lane order");
    send(8'h63, 64'hFFFF_FF80_007F_0000, 64'hFFFE_0010_FF81_0070, "R6 word in-range edges");
    // R3: word saturation boundaries
    send(8'h63, 64'h0080_FF7F_7FFF_8000, 64'h0000_0000_0000_0000, "R3 word clamp");
    idle(2);
    send(8'h63, 64'h0, 64'h0100_FE00_0080_FF7F, "R3 R2 word clamp high half");
    // R4 R6: dword order
    send(8'h6B, 64'h0000_2222_0000_1111, 64'hFFFF_CCCC_0000_3333, "R4 R6 dword lane order");
    // R5: dword saturation
    send(8'h6B, 64'h0000_8000_FFFF_7FFF, 64'h7FFF_FFFF_8000_0000, "R5 dword clamp");
    send(8'h6B, 64'h0000_7FFF_FFFF_8000, 64'h0, "R5 R6 dword exact limits");
    idle(3);
    // R7: unrecognised opcodes
    send(8'h00, 64'h1234, 64'h5678, "R7 illegal 0x00 zero result");
    send(8'h6A, 64'h7FFF_7FFF, 64'h1, "R7 illegal 0x6A zero result");
    send(8'h63, 64'h0, 64'h0, "R7 legal clears illegal");
    idle(2);
    for (int k = 0; k < 300; k++) begin
      logic [7:0] op;
      int sel = $urandom_range(0, 9);
      op = (sel < 4) ? 8'h63 : (sel < 8) ? 8'h6B : 8'($urandom);
      send(op, {$urandom, $urandom}, {$urandom, $urandom}, "R1 R2 R3 R4 R5 R8 random");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(3);
    // R10: mid-run reset clears outputs
    @(negedge clk); rst = 1;
    reset_check();
    @(negedge clk); rst = 0; seen = 0;
    idle(2);
    send(8'h6B, 64'h1, 64'h2, "R8 after reset");
    idle(3);
    check(sb.size() == 0, "R8 all results delivered", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule